// File: doc/BRIEF.md
# Line-Reversing Memory Rotator

This block is an AXI4 read/write master that turns a byte image in external memory through 180 degrees. The image is 24 lines of 64 one-byte characters, 1536 bytes in all. The source sits at address 0x0000 and the rotated copy goes to the region that starts at 0x1800.

A rising edge on `start` begins a job. The engine then takes one line at a time. It reads the line as a single forward burst and stores it in a local buffer with its bytes reversed. It then writes the line back as a single burst into the mirrored line slot of the destination. The read of the next line waits until the write response for the current line has arrived.

After the 24th write response the engine pulses `done` and returns to idle, where it waits for a new start edge. Any error response seen during a job raises a sticky error flag. The job still runs to the end.

Top module: `line_rotator`

## Requirements
- R1: While reset is asserted and just after it, `arvalid`, `awvalid`, `wvalid`, `rready`, `bready`, `done` and `err` are all low.
- R2: A job begins only on a low-to-high transition of `start` seen while idle. Holding `start` high does not begin another job. A new edge that arrives during a job is ignored.
- R3: Line i (0..23) is read from address SRC_BASE + 64·i as one burst with `arlen` = 15 (16 beats), `arsize` = 2 (4 bytes) and `arburst` = 2'b01 (INCR).
- R4: Line i is written to address DST_BASE + 64·(23 − i) as one INCR burst with `awlen` = 15 and `awsize` = 2. Every beat has `wstrb` = 4'b1111, and `wlast` is high on the 16th beat only.
- R5: After a job, destination byte k (0..1535) equals source byte 1535 − k. Bytes are reversed both within each 32-bit beat and across the beats of a line.
- R6: At most one line is in flight. A new read address is issued only after the write response of the previous line has been accepted.
- R7: `done` is high for exactly one cycle, in the cycle after the 24th write response is accepted. The engine is then idle with `arvalid` low.
- R8: A non-zero `rresp` or `bresp` sets `err`. `err` stays set until the next accepted start edge clears it, and the job still completes all 24 lines.
- R9: While `arvalid` or `wvalid` is high without its ready, the address or data it carries does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job trigger, acted on at its rising edge |
| done | output | 1 | One-cycle pulse when the last line is written |
| err | output | 1 | Sticky flag for any error response in the current job |
| araddr | output | 32 | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Last read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| awaddr | output | 32 | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wlast | output | 1 | Last write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
`arvalid` for line 0 rises one clock after the clock edge that sees the start edge. Each later read address follows the accepted write response by one clock. `done` and `err` change one clock after the handshake that causes them.

The length of a whole job depends on the random stalls in the slave, so the bench never counts cycles to find the end of a job. It samples on the falling edge and waits for the `done` pulse, then lets ten more cycles pass before it reads any results. Per-handshake properties, such as address values, ordering and hold while stalled, are recorded by the slave model in the cycle of the handshake and are judged once the job has finished.

// File: rtl/line_rotator.sv
module line_rotator #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_BYTES = 64,
  parameter int LINES = 24,
  parameter logic [ADDR_W-1:0] SRC_BASE = '0,
  parameter logic [ADDR_W-1:0] DST_BASE = 'h1800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                done,
  output logic                err,
  output logic [ADDR_W-1:0]   araddr,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic [1:0]          arburst,
  output logic                arvalid,
  input  logic                arready,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  input  logic                rlast,
  input  logic                rvalid,
  output logic                rready,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready
);

  localparam int STRB_W = DATA_W / 8;
  localparam int BEATS  = LINE_BYTES / STRB_W;
  localparam int BW     = $clog2(BEATS);
  localparam int LW     = $clog2(LINES);
  localparam logic [BW-1:0]     LAST_BEAT = BW'(BEATS - 1);
  localparam logic [LW-1:0]     LAST_LINE = LW'(LINES - 1);
  localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] TOP_SLOT  = ADDR_W'(LINES - 1);
  localparam logic [ADDR_W-1:0] SRC_END   = SRC_BASE + ADDR_W'(LINES * LINE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_AR, S_R, S_AW, S_W, S_B} state_t;

  state_t            state;
  logic              start_q;
  logic [LW-1:0]     line;
  logic [BW-1:0]     beat;
  logic [DATA_W-1:0] lbuf [BEATS];
  logic [ADDR_W-1:0] line_ext;

  function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < STRB_W; i++) r[8*i +: 8] = d[8*(STRB_W-1-i) +: 8];
    return r;
  endfunction

  wire start_edge = start & ~start_q;

  assign line_ext = {{(ADDR_W-LW){1'b0}}, line};

  assign araddr  = SRC_BASE + line_ext * STRIDE;
  assign arlen   = 8'(BEATS - 1);
  assign arsize  = 3'($clog2(STRB_W));
  assign arburst = 2'b01;
  assign arvalid = (state == S_AR);
  assign rready  = (state == S_R);

  assign awaddr  = DST_BASE + (TOP_SLOT - line_ext) * STRIDE;
  assign awlen   = 8'(BEATS - 1);
  assign awsize  = 3'($clog2(STRB_W));
  assign awburst = 2'b01;
  assign awvalid = (state == S_AW);
  assign wvalid  = (state == S_W);
  assign wdata   = lbuf[beat];
  assign wstrb   = '1;
  assign wlast   = (beat == LAST_BEAT);
  assign bready  = (state == S_B);

  always_ff @(posedge clk)
    if (state == S_R && rvalid) lbuf[LAST_BEAT - beat] <= swap_bytes(rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      start_q <= 1'b0;
      line    <= '0;
      beat    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      start_q <= start;
      done    <= 1'b0;
      case (state)
        S_IDLE: if (start_edge) begin
          line  <= '0;
          err   <= 1'b0;
          state <= S_AR;
        end
        S_AR: if (arready) begin
          beat  <= '0;
          state <= S_R;
        end
        S_R: if (rvalid) begin
          beat <= beat + 1'b1;
          if (rresp != 2'b00) err <= 1'b1;
          if (rlast) state <= S_AW;
        end
        S_AW: if (awready) begin
          beat  <= '0;
          state <= S_W;
        end
        S_W: if (wready) begin
          beat <= beat + 1'b1;
          if (wlast) state <= S_B;
        end
        S_B: if (bvalid) begin
          if (bresp != 2'b00) err <= 1'b1;
          if (line == LAST_LINE) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            line  <= line + 1'b1;
            state <= S_AR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic          line_open;
  logic [BW-1:0] wb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_open <= 1'b0;
      wb_seen   <= '0;
    end else begin
      if (arvalid && arready) line_open <= 1'b1;
      else if (bvalid && bready) line_open <= 1'b0;
      if (awvalid && awready) wb_seen <= '0;
      else if (wvalid && wready) wb_seen <= wb_seen + 1'b1;
    end
  end

  // R6
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> !line_open);

  // R9
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));

  // R9
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

  // R4
  wlast_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && wready && wlast |-> wb_seen == LAST_BEAT);

  // R3
  ar_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> araddr >= SRC_BASE && araddr < SRC_END);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(start && !start_q) |=> err);

endmodule

// File: tb/line_rotator_bench.sv
module line_rotator_bench;

  localparam int IMG = 1536;
  localparam int NLINES = 24;
  localparam logic [31:0] DST = 32'h1800;

  // fields: [7:0] seed, [8] stall, [10:9] inject (0 none, 1 rresp, 2 bresp), [11] expected err
  localparam logic [11:0] VECS [5] = '{
    12'h011, 12'h15A, 12'hB33, 12'h0C7, 12'hD80
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic done, err;
  logic [31:0] araddr, awaddr, wdata;
  logic [7:0] arlen, awlen;
  logic [2:0] arsize, awsize;
  logic [1:0] arburst, awburst;
  logic arvalid, rready, awvalid, wlast, wvalid, bready;
  logic [3:0] wstrb;
  logic arready = 0, rvalid = 0, rlast = 0, awready = 0, wready = 0, bvalid = 0;
  logic [31:0] rdata = 0;
  logic [1:0] rresp = 0, bresp = 0;

  always #5 clk = ~clk;

  line_rotator u_line_rotator (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .arvalid(arvalid), .arready(arready), .rdata(rdata), .rresp(rresp),
    .rlast(rlast), .rvalid(rvalid), .rready(rready),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb),
    .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready)
  );

  logic [7:0] mem [3072];
  logic [15:0] lfsr = 16'hACE1;
  logic stall = 0;
  logic [1:0] inj = 0;
  logic rd_busy = 0, wr_busy = 0, bpend = 0;
  logic [31:0] rd_base = 0, wr_base = 0;
  int rcnt = 0, wcnt = 0;
  int ar_seen = 0, b_seen = 0, ar_err = 0, aw_err = 0, ord_err = 0, hold_err = 0;
  logic ar_wait = 0, w_wait = 0;
  logic [31:0] ar_prev = 0, w_prev = 0;
  int done_cnt = 0;
  int checks = 0, fails = 0, cyc = 0;

  function automatic int midx(input logic [31:0] a);
    int i;
    i = (a < DST) ? int'(a) : int'(a - DST) + IMG;
    return (i < 3072) ? i : 0;
  endfunction

  always @(posedge clk) begin
    logic go;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    go = stall ? lfsr[0] : 1'b1;
    if (ar_wait && (!arvalid || araddr != ar_prev)) hold_err <= hold_err + 1;
    if (w_wait && (!wvalid || wdata != w_prev)) hold_err <= hold_err + 1;
    ar_wait <= arvalid && !arready;
    ar_prev <= araddr;
    w_wait  <= wvalid && !wready;
    w_prev  <= wdata;
    if (arvalid && arready) begin
      if (araddr != 32'(64 * ar_seen) || arlen != 8'd15 || arsize != 3'd2 || arburst != 2'b01)
        ar_err <= ar_err + 1;
      if (ar_seen != b_seen) ord_err <= ord_err + 1;
      rd_base <= araddr; rd_busy <= 1; rcnt <= 0; ar_seen <= ar_seen + 1;
    end
    arready <= !rd_busy && !(arvalid && arready) && go;
    if (rvalid && rready) begin
      rvalid <= 0; rcnt <= rcnt + 1;
      if (rlast) rd_busy <= 0;
    end else if (rd_busy && !rvalid && go) begin
      rvalid <= 1;
      for (int b = 0; b < 4; b++) rdata[8*b +: 8] <= mem[midx(rd_base + 32'(4 * rcnt + b))];
      rlast <= (rcnt == 15);
      rresp <= (inj == 2'd1 && ar_seen == 8 && rcnt == 3) ? 2'b10 : 2'b00;
    end
    if (awvalid && awready) begin
      if (awaddr != DST + 32'(64 * (NLINES - 1 - b_seen)) || awlen != 8'd15 || awsize != 3'd2 || awburst != 2'b01)
        aw_err <= aw_err + 1;
      wr_base <= awaddr; wr_busy <= 1; wcnt <= 0;
    end
    awready <= !wr_busy && !(awvalid && awready) && go;
    wready <= go;
    if (wvalid && wready) begin
      if (!wr_busy || wstrb != 4'hF || wlast != (wcnt == 15)) aw_err <= aw_err + 1;
      for (int b = 0; b < 4; b++) mem[midx(wr_base + 32'(4 * wcnt + b))] <= wdata[8*b +: 8];
      wcnt <= wcnt + 1;
      if (wlast) begin wr_busy <= 0; bpend <= 1; end
    end
    if (bvalid && bready) begin
      bvalid <= 0; b_seen <= b_seen + 1;
    end else if (bpend && !bvalid) begin
      bvalid <= 1; bpend <= 0;
      bresp <= (inj == 2'd2 && b_seen == 7) ? 2'b10 : 2'b00;
    end
  end

  always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic run_job(input logic [7:0] seed, input logic stl, input logic [1:0] mode,
                         input bit hold, input bit poke);
    int t;
    for (int k = 0; k < IMG; k++) begin
      mem[k] = 8'(k * 7) ^ seed ^ 8'(k >> 6);
      mem[IMG + k] = 8'hEE;
    end
    @(negedge clk);
    stall = stl; inj = mode;
    ar_seen = 0; b_seen = 0; ar_err = 0; aw_err = 0; ord_err = 0; hold_err = 0; done_cnt = 0;
    start = 1;
    repeat (3) @(negedge clk);
    if (!hold) start = 0;
    t = 0;
    while (done_cnt == 0 && t < 40000) begin
      @(negedge clk); t++;
      if (poke && t == 400) start = 0;
      if (poke && t == 402) start = 1;
      if (poke && t == 405) start = 0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic judge(input bit exp_err);
    int bad;
    bad = 0;
    for (int k = 0; k < IMG; k++) if (mem[IMG + k] !== mem[IMG - 1 - k]) bad++;
    chk(bad == 0, "R5 rotated bytes mismatch", bad, 0);
    chk(ar_err == 0 && ar_seen == NLINES, "R3 read bursts", ar_seen - 100 * ar_err, NLINES);
    chk(aw_err == 0 && b_seen == NLINES, "R4 write bursts", b_seen - 100 * aw_err, NLINES);
    chk(ord_err == 0, "R6 line ordering", ord_err, 0);
    chk(hold_err == 0, "R9 hold while stalled", hold_err, 0);
    chk(done_cnt == 1, "R7 done pulse cycles", done_cnt, 1);
    chk(arvalid == 0, "R7 idle after done", arvalid, 0);
    chk(err == exp_err, "R8 error flag", err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({arvalid, awvalid, wvalid, rready, bready, done, err} == 0, "R1 reset outputs",
        {arvalid, awvalid, wvalid, rready, bready, done, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({arvalid, awvalid, wvalid, done, err} == 0, "R1 after reset release",
        {arvalid, awvalid, wvalid, done, err}, 0);

    for (int v = 0; v < 5; v++) begin
      run_job(VECS[v][7:0], VECS[v][8], VECS[v][10:9], 0, 0);
      judge(VECS[v][11]);
      if (VECS[v][11]) begin
        repeat (50) @(negedge clk);
        chk(err == 1, "R8 error sticky after done", err, 1);
      end
    end

    // R2: held start level must not retrigger
    run_job(8'h3C, 1, 0, 1, 0);
    judge(0);
    repeat (200) @(negedge clk);
    chk(ar_seen == NLINES && arvalid == 0, "R2 held start no retrigger", ar_seen, NLINES);
    start = 0;
    repeat (5) @(negedge clk);

    // R2: a fresh edge during a job is ignored
    run_job(8'h99, 1, 0, 0, 1);
    judge(0);
    repeat (100) @(negedge clk);
    chk(ar_seen == NLINES, "R2 edge while busy ignored", ar_seen, NLINES);

    finish_run();
  end

endmodule